// File: doc/BRIEF.md
# Byte-Wide Finite-Field Accumulator Unit

This block is the arithmetic core of a small cipher-oriented processor. It keeps one 8-bit accumulator and, each enabled cycle, replaces it with the result of one finite-field operation. The operation works on the accumulator and an 8-bit operand. The operations are:
- load a byte
- add a byte (XOR)
- double in GF(2^8)
- halve in GF(2^8)
- fused double-then-add
- fused halve-then-add

Column-mixing and key-schedule arithmetic are issued as short opcode chains on single bytes, so no 32-bit word is ever assembled. Intermediate values stay in the accumulator and do not pass through data memory.

Halving is the exact inverse of doubling. A controller can therefore step the round constant and the key schedule backwards for decryption instead of storing every round key. A store opcode presents the accumulator on a write-back port for one cycle. The controller uses that port to copy the result into its register memory.

Top module: `gf8_mac_unit`

## Requirements
- R1: On a synchronous active-high reset the accumulator reads 0x00 and the write-back valid output is low.
- R2: Opcode 0 (load) with enable high sets the accumulator to the operand at the next clock edge.
- R3: Opcode 1 (add) with enable high sets the accumulator to accumulator XOR operand.
- R4: Opcode 2 (double) sets the accumulator to (acc<<1) truncated to 8 bits, XORed with 0x1B when the old bit 7 was 1. The operand is not used.
- R5: Opcode 3 (halve) sets the accumulator to acc>>1, XORed with 0x8D when the old bit 0 was 1. Halving after doubling returns the original byte for all 256 values.
- R6: Opcode 4 (double-add) sets the accumulator to double(acc) XOR operand.
- R7: Opcode 5 (halve-add) sets the accumulator to halve(acc) XOR operand.
- R8: With enable low, the accumulator keeps its value and write-back valid stays low, whatever the opcode and operand.
- R9: Opcode 6 (store) with enable high raises write-back valid for exactly one cycle after the edge. During that cycle the write-back data equals the accumulator, and the accumulator is unchanged.
- R10: Opcode 7 (no-op) with enable high leaves the accumulator unchanged and raises no write-back.
- R11: The chain load a0, add a1, double, add a1, add a2, add a3 leaves 2·a0 ^ 3·a1 ^ a2 ^ a3 in the accumulator. This is one column-mixing output byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Execute the presented opcode this cycle |
| op_i | input | 3 | Opcode (0 load, 1 add, 2 double, 3 halve, 4 double-add, 5 halve-add, 6 store, 7 no-op) |
| opnd_i | input | 8 | Byte operand |
| acc_o | output | 8 | Registered accumulator value |
| wb_vld_o | output | 1 | Write-back strobe, one cycle per store |
| wb_data_o | output | 8 | Registered write-back byte |

## Verification
The accumulator is the only state. A wrong reduction constant, a wrong shift direction or a wrong opcode decode therefore appears on acc_o one cycle after the offending instruction. Errors in the reduction terms only show for inputs with the top or bottom bit set. For that reason the double/halve round trip is swept over every byte, and the column-mixing chain is run with several operand sets. A write-back fault shows in the cycle after a store, either as a strobe that is missing or too long or as the wrong data. A hold fault shows on the next sample after an idle or disabled cycle.

// File: rtl/gf8_mac_pkg.sv
package gf8_mac_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 3'd0,
    OP_ADD   = 3'd1,
    OP_DBL   = 3'd2,
    OP_HLV   = 3'd3,
    OP_DADD  = 3'd4,
    OP_HADD  = 3'd5,
    OP_STORE = 3'd6,
    OP_NOP   = 3'd7
  } gf_op_e;

  typedef struct packed {
    logic load_src;   // take operand as base value
    logic use_dbl;    // pass accumulator through doubler
    logic use_hlv;    // pass accumulator through halver
    logic add_opnd;   // XOR operand into result
    logic wr_acc;     // update the accumulator
    logic store;      // issue write-back
  } gf_ctl_t;
endpackage

// File: rtl/gf_xtime.sv
module gf_xtime #(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'h1B
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_i
);
  logic [W-1:0] shifted;
  always_comb begin
    shifted = {a_i[W-2:0], 1'b0};
    y_i     = a_i[W-1] ? (shifted ^ POLY) : shifted;
  end
endmodule

// File: rtl/gf_xhalf.sv
module gf_xhalf #(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'h1B
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_i
);
  // halving constant: low polynomial bits shifted down with the top bit set
  localparam logic [W-1:0] HCONST = {1'b1, POLY[W-1:1]};
  logic [W-1:0] shifted;
  always_comb begin
    shifted = {1'b0, a_i[W-1:1]};
    y_i     = a_i[0] ? (shifted ^ HCONST) : shifted;
  end
endmodule

// File: rtl/gf8_op_decode.sv
module gf8_op_decode
  import gf8_mac_pkg::*;
(
  input  logic            en_i,
  input  logic [OPW-1:0]  op_i,
  output gf_ctl_t         ctl_o
);
  always_comb begin
    ctl_o = '0;
    if (en_i) begin
      unique case (gf_op_e'(op_i))
        OP_LOAD:  begin ctl_o.load_src = 1'b1; ctl_o.wr_acc = 1'b1; end
        OP_ADD:   begin ctl_o.add_opnd = 1'b1; ctl_o.wr_acc = 1'b1; end
        OP_DBL:   begin ctl_o.use_dbl  = 1'b1; ctl_o.wr_acc = 1'b1; end
        OP_HLV:   begin ctl_o.use_hlv  = 1'b1; ctl_o.wr_acc = 1'b1; end
        OP_DADD:  begin ctl_o.use_dbl  = 1'b1; ctl_o.add_opnd = 1'b1; ctl_o.wr_acc = 1'b1; end
        OP_HADD:  begin ctl_o.use_hlv  = 1'b1; ctl_o.add_opnd = 1'b1; ctl_o.wr_acc = 1'b1; end
        OP_STORE: ctl_o.store = 1'b1;
        default:  ctl_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gf8_mac_unit.sv
module gf8_mac_unit
  import gf8_mac_pkg::*;
#(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'h1B
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_i,
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   opnd_i,
  output logic [W-1:0]   acc_o,
  output logic           wb_vld_o,
  output logic [W-1:0]   wb_data_o
);
  gf_ctl_t      ctl;
  logic [W-1:0] acc_q;
  logic [W-1:0] dbl_v, hlv_v, base_v, nxt_v;

  gf8_op_decode u_dec (.en_i(en_i), .op_i(op_i), .ctl_o(ctl));

  gf_xtime #(.W(W), .POLY(POLY)) u_dbl (.a_i(acc_q), .y_i(dbl_v));
  gf_xhalf #(.W(W), .POLY(POLY)) u_hlv (.a_i(acc_q), .y_i(hlv_v));

  always_comb begin
    if (ctl.load_src)     base_v = opnd_i;
    else if (ctl.use_dbl) base_v = dbl_v;
    else if (ctl.use_hlv) base_v = hlv_v;
    else                  base_v = acc_q;
    nxt_v = ctl.add_opnd ? (base_v ^ opnd_i) : base_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      wb_vld_o  <= 1'b0;
      wb_data_o <= '0;
    end else begin
      if (ctl.wr_acc) acc_q <= nxt_v;
      wb_vld_o <= ctl.store;
      if (ctl.store) wb_data_o <= acc_q;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/gf8_mac_unit_chk.sv
module gf8_mac_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] opnd_i,
  input logic [W-1:0] acc_o,
  input logic         wb_vld_o,
  input logic [W-1:0] wb_data_o
);
  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && op_i == 3'd0) |=> acc_o == $past(opnd_i));
  // R3
  add_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && op_i == 3'd1) |=> acc_o == ($past(acc_o) ^ $past(opnd_i)));
  // R4
  dbl_plain_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && op_i == 3'd2 && !acc_o[W-1]) |=> acc_o == {$past(acc_o[W-2:0]), 1'b0});
  // R5
  hlv_plain_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && op_i == 3'd3 && !acc_o[0]) |=> acc_o == {1'b0, $past(acc_o[W-1:1])});
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ($stable(acc_o) && !wb_vld_o));
  // R9
  store_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && op_i == 3'd6) |=> (wb_vld_o && wb_data_o == $past(acc_o) && $stable(acc_o)));
  // R9
  wb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wb_vld_o |-> $past(en_i && op_i == 3'd6));
  // R10
  nop_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && op_i == 3'd7) |=> ($stable(acc_o) && !wb_vld_o));
endmodule

bind gf8_mac_unit gf8_mac_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .op_i(op_i), .opnd_i(opnd_i),
  .acc_o(acc_o), .wb_vld_o(wb_vld_o), .wb_data_o(wb_data_o)
);

// File: tb/gf8_mac_unit_tb.sv
module gf8_mac_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic [2:0] op_i = 3'd7;
  logic [7:0] opnd_i = 8'h00;
  logic [7:0] acc_o, wb_data_o;
  logic       wb_vld_o;
  int errs = 0;
  int chks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gf8_mac_unit u_dut (.clk(clk), .rst(rst), .en_i(en_i), .op_i(op_i),
    .opnd_i(opnd_i), .acc_o(acc_o), .wb_vld_o(wb_vld_o), .wb_data_o(wb_data_o));

  function automatic logic [7:0] ref_dbl(input logic [7:0] x);
    logic [8:0] t;
    t = {x, 1'b0};
    if (t[8]) t = t ^ 9'h11B;
    return t[7:0];
  endfunction

  // halve found by search: the byte whose double is x
  function automatic logic [7:0] ref_hlv(input logic [7:0] x);
    for (int i = 0; i < 256; i++)
      if (ref_dbl(8'(i)) == x) return 8'(i);
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    chks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // drive at negedge, one posedge, sample at following negedge
  task automatic issue(input logic en, input logic [2:0] op, input logic [7:0] d);
    en_i = en; op_i = op; opnd_i = d;
    @(negedge clk);
    en_i = 1'b0; op_i = 3'd7; opnd_i = 8'h00;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 acc", acc_o, 8'h00);
    check("R1 wb_vld", {7'd0, wb_vld_o}, 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_load_add();
    issue(1, 3'd0, 8'hA5); check("R2 load", acc_o, 8'hA5);
    issue(1, 3'd1, 8'h3C); check("R3 add", acc_o, 8'h99);
  endtask

  task automatic t_dbl_hlv();
    issue(1, 3'd0, 8'h57); issue(1, 3'd2, 8'hFF); check("R4 dbl no-red", acc_o, 8'hAE);
    issue(1, 3'd2, 8'h00); check("R4 dbl red", acc_o, 8'h47);
    issue(1, 3'd0, 8'h03); issue(1, 3'd3, 8'hFF); check("R5 hlv odd", acc_o, 8'h8C);
    issue(1, 3'd0, 8'h80); issue(1, 3'd3, 8'h00); check("R5 hlv even", acc_o, 8'h40);
  endtask

  task automatic t_roundtrip();
    for (int x = 0; x < 256; x++) begin
      issue(1, 3'd0, 8'(x));
      issue(1, 3'd2, 8'h00);
      check("R4 dbl sweep", acc_o, ref_dbl(8'(x)));
      issue(1, 3'd3, 8'h00);
      check("R5 roundtrip", acc_o, 8'(x));
    end
  endtask

  task automatic t_fused();
    issue(1, 3'd0, 8'h9E); issue(1, 3'd4, 8'h21);
    check("R6 dadd", acc_o, ref_dbl(8'h9E) ^ 8'h21);
    issue(1, 3'd5, 8'h0F);
    check("R7 hadd", acc_o, ref_hlv(ref_dbl(8'h9E) ^ 8'h21) ^ 8'h0F);
  endtask

  task automatic t_hold();
    issue(1, 3'd0, 8'h6D);
    for (int o = 0; o < 8; o++) begin
      issue(0, 3'(o), 8'hFF);
      check("R8 hold acc", acc_o, 8'h6D);
      check("R8 no wb", {7'd0, wb_vld_o}, 8'h00);
    end
    issue(1, 3'd7, 8'hFF);
    check("R10 nop acc", acc_o, 8'h6D);
    check("R10 nop wb", {7'd0, wb_vld_o}, 8'h00);
  endtask

  task automatic t_store();
    issue(1, 3'd0, 8'hC3);
    issue(1, 3'd6, 8'h11);
    check("R9 wb_vld", {7'd0, wb_vld_o}, 8'h01);
    check("R9 wb_data", wb_data_o, 8'hC3);
    check("R9 acc kept", acc_o, 8'hC3);
    @(negedge clk);
    check("R9 one-cycle", {7'd0, wb_vld_o}, 8'h00);
  endtask

  task automatic t_mix(input logic [7:0] a0, input logic [7:0] a1,
                       input logic [7:0] a2, input logic [7:0] a3);
    issue(1, 3'd0, a0); issue(1, 3'd1, a1); issue(1, 3'd2, 8'h00);
    issue(1, 3'd1, a1); issue(1, 3'd1, a2); issue(1, 3'd1, a3);
    check("R11 mix", acc_o, ref_dbl(a0) ^ ref_dbl(a1) ^ a1 ^ a2 ^ a3);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_load_add();
    t_dbl_hlv();
    t_roundtrip();
    t_fused();
    t_hold();
    t_store();
    t_mix(8'hDB, 8'h13, 8'h53, 8'h45);
    t_mix(8'hF2, 8'h0A, 8'h22, 8'h5C);
    t_mix(8'h80, 8'hFF, 8'h01, 8'h7E);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errs++; chks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule